// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer with Capture

This block is a down-counting timer with a width set by a parameter (16 bits by default). It has four operating modes. In free-running timer mode the counter steps on a selected count tick and reloads itself when it underflows. In event mode it counts edges of an external input pin instead. The two measurement modes copy the counter into a capture register when the pin delivers a trigger edge and then restart the interval. Period mode triggers on one pin edge, chosen by a bit. High/low mode triggers on every pin edge, so successive captures give alternating high and low widths.

A small register port configures and reads the block. Register 0 holds the mode, the edge-select bit and the stop bit. Register 1 holds the count-tick selection. Register 2 writes the reload value and reads the count. Register 3 holds the two sticky interrupt request flags. The pin is brought into the clock domain by a synchroniser before any edge is detected. The count tick comes from a free-running prescaler: the clock divided by 16, the clock divided by 2, or a single-cycle tick from an internal oscillator.

Each capture stays frozen until software reads register 2 once. A trigger that arrives while a capture is unread only restarts the interval. This lets slow software read a value without tearing it.

Top module: `mmtimer`

## Requirements
- R1: After reset the counter and the reload value are all ones, registers 0 and 1 read 0, and both interrupt flags read 0.
- R2: In register 0, bits [1:0] hold the mode (0 free timer, 1 period, 2 event, 3 high/low), bit 2 holds the edge-select bit and bit 3 holds the stop bit. In register 1, bits [1:0] hold the tick source. Every other bit of registers 0 and 1 reads 0. A write to register 2 loads the reload value and the counter together. A read of register 2 returns the capture register in modes 1 and 3 and the live counter in modes 0 and 2. In register 3, bit 0 is the underflow flag and bit 1 is the pin flag. Writing 0 to a flag bit clears it and writing 1 leaves it as it is.
- R3: Tick source 0 steps the counter once every 16 clocks. Source 1 steps it every 2 clocks. Source 2 steps it once per cycle in which the oscillator tick is high. Source 3 stops counting in every mode except event mode.
- R4: A count step with the counter at 0 reloads the counter from the reload value and sets the underflow flag. The flag stays set until it is cleared.
- R5: While the stop bit is 1, the counter does not change except when register 2 is written, and measurement triggers have no effect.
- R6: In event mode the counter steps on rising pin edges when the edge-select bit is 0 and on falling pin edges when it is 1. The tick source setting is ignored.
- R7: In period mode the trigger is the falling edge when the edge-select bit is 0 and the rising edge when it is 1. A trigger copies the counter into the capture register and reloads the counter.
- R8: In high/low mode both pin edges are triggers, whatever the edge-select bit is.
- R9: A capture is held until register 2 is read. A trigger that arrives while a capture is held reloads the counter but leaves the capture unchanged.
- R10: The pin flag is set by falling edges when the edge-select bit is 0 and by rising edges when it is 1. In high/low mode both edges set it.
- R11: A pin change made between clock edges takes effect at the third rising clock edge after it, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of register 2 releases a held capture |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for the selected register (combinational) |
| osc_tick | input | 1 | Single-cycle tick from the internal oscillator |
| pin_in | input | 1 | External pin, asynchronous |
| irq_uflow | output | 1 | Sticky underflow interrupt request |
| irq_edge | output | 1 | Sticky pin-edge interrupt request |

## Verification
The assertions check, on every cycle, that a stopped counter does not move and that an underflow in timer mode raises its flag. They also check that a held capture neither changes nor releases itself, that event mode counts no edge it should ignore, that both edges flag in high/low mode, and that unused register bits read 0. The bench scenarios show the quantities that need a history: the exact step rate of each tick source, captured intervals over random tick counts, the capture value kept across an extra trigger, and the three-edge delay of the pin.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

   typedef enum logic [1:0] {
      MD_FREE   = 2'd0,
      MD_PERIOD = 2'd1,
      MD_EVENT  = 2'd2,
      MD_HILO   = 2'd3
   } mmt_mode_e;

   typedef enum logic [1:0] {
      SRC_SLOW = 2'd0,
      SRC_FAST = 2'd1,
      SRC_OSC  = 2'd2,
      SRC_OFF  = 2'd3
   } mmt_src_e;

   localparam logic [1:0] REG_CTRL  = 2'd0;
   localparam logic [1:0] REG_SRC   = 2'd1;
   localparam logic [1:0] REG_COUNT = 2'd2;
   localparam logic [1:0] REG_FLAGS = 2'd3;

   typedef struct packed {
      logic      stop;
      logic      edge_sel;
      mmt_mode_e mode;
   } mmt_ctrl_t;

endpackage

// File: rtl/mmt_sync.sv
module mmt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mmt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/mmt_prescale.sv
module mmt_prescale
   import mmt_pkg::*;
#(
   parameter int SLOW_DIV = 16,
   parameter int FAST_DIV = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  mmt_src_e src_i,
   input  logic     osc_i,
   output logic     tick_o
);

   localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
   localparam int FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;

   if ((1 << SW) != SLOW_DIV || SLOW_DIV < 2) begin : g_bad_slow
      $error("mmt_prescale: SLOW_DIV must be a power of two of at least 2");
   end
   if ((1 << FW) != FAST_DIV || FAST_DIV < 2 || FAST_DIV > SLOW_DIV) begin : g_bad_fast
      $error("mmt_prescale: FAST_DIV must be a power of two between 2 and SLOW_DIV");
   end

   logic [SW-1:0] div_q;
   logic          slow_tick;
   logic          fast_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   assign slow_tick = &div_q;

   if (FW == SW) begin : g_fast_full
      assign fast_tick = &div_q;
   end else begin : g_fast_part
      assign fast_tick = &div_q[FW-1:0];
   end

   always_comb begin
      unique case (src_i)
         SRC_SLOW: tick_o = slow_tick;
         SRC_FAST: tick_o = fast_tick;
         SRC_OSC:  tick_o = osc_i;
         default:  tick_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/mmt_regs.sv
module mmt_regs
   import mmt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [1:0]       sel_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             uflow_set_i,
   input  logic             edge_set_i,
   output mmt_ctrl_t        ctrl_o,
   output mmt_src_e         src_o,
   output logic [CNT_W-1:0] reload_o,
   output logic             flag_uflow_o,
   output logic             flag_edge_o,
   output logic             load_o
);

   logic wr_ctrl, wr_src, wr_flags;
   logic unused_wbits;

   assign wr_ctrl  = wr_i && (sel_i == REG_CTRL);
   assign wr_src   = wr_i && (sel_i == REG_SRC);
   assign wr_flags = wr_i && (sel_i == REG_FLAGS);
   assign load_o   = wr_i && (sel_i == REG_COUNT);

   assign unused_wbits = ^wdata_i[CNT_W-1:4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o   <= '{stop: 1'b0, edge_sel: 1'b0, mode: MD_FREE};
         src_o    <= SRC_SLOW;
         reload_o <= '1;
      end else begin
         if (wr_ctrl) begin
            ctrl_o.mode     <= mmt_mode_e'(wdata_i[1:0]);
            ctrl_o.edge_sel <= wdata_i[2];
            ctrl_o.stop     <= wdata_i[3];
         end
         if (wr_src) src_o <= mmt_src_e'(wdata_i[1:0]);
         if (load_o) reload_o <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_uflow_o <= 1'b0;
         flag_edge_o  <= 1'b0;
      end else begin
         flag_uflow_o <= uflow_set_i | (flag_uflow_o & ~(wr_flags & ~wdata_i[0]));
         flag_edge_o  <= edge_set_i  | (flag_edge_o  & ~(wr_flags & ~wdata_i[1]));
      end
   end

endmodule

// File: rtl/mmt_core.sv
module mmt_core
   import mmt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mmt_ctrl_t        ctrl_i,
   input  logic             src_tick_i,
   input  logic             rise_i,
   input  logic             fall_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             release_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cap_o,
   output logic             held_o,
   output logic             uflow_o,
   output logic             pinirq_o
);

   logic count_edge;
   logic trig;
   logic step;
   logic run_trig;

   assign count_edge = ctrl_i.edge_sel ? fall_i : rise_i;

   always_comb begin
      unique case (ctrl_i.mode)
         MD_PERIOD: trig = ctrl_i.edge_sel ? rise_i : fall_i;
         MD_HILO:   trig = rise_i | fall_i;
         default:   trig = 1'b0;
      endcase
   end

   assign step     = ~ctrl_i.stop & ((ctrl_i.mode == MD_EVENT) ? count_edge : src_tick_i);
   assign run_trig = ~ctrl_i.stop & trig;
   assign uflow_o  = ~load_i & ~run_trig & step & (cnt_o == '0);
   assign pinirq_o = (ctrl_i.mode == MD_HILO) ? (rise_i | fall_i)
                                              : (ctrl_i.edge_sel ? rise_i : fall_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '1;
         cap_o <= '0;
      end else if (load_i) begin
         cnt_o <= load_val_i;
      end else if (run_trig) begin
         if (!held_o) cap_o <= cnt_o;
         cnt_o <= reload_i;
      end else if (step) begin
         cnt_o <= (cnt_o == '0) ? reload_i : cnt_o - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   held_o <= 1'b0;
      else if (run_trig && !held_o) held_o <= 1'b1;
      else if (release_i)           held_o <= 1'b0;
   end

endmodule

// File: rtl/mmtimer.sv
module mmtimer
   import mmt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int SLOW_DIV    = 16,
   parameter int FAST_DIV    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_sel,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic             osc_tick,
   input  logic             pin_in,
   output logic             irq_uflow,
   output logic             irq_edge
);

   if (CNT_W < 4) begin : g_bad_width
      $error("mmtimer: CNT_W must be at least 4");
   end

   mmt_ctrl_t        ctrl;
   mmt_src_e         src_sel;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cap_q;
   logic             held_q;
   logic             src_tick;
   logic             pin_rise, pin_fall;
   logic             load_cnt;
   logic             rd_release;
   logic             uflow_pulse, pinirq_pulse;
   logic             measuring;

   assign rd_release = bus_rd && (bus_sel == REG_COUNT);
   assign measuring  = (ctrl.mode == MD_PERIOD) || (ctrl.mode == MD_HILO);

   mmt_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_in),
      .rise_o (pin_rise),
      .fall_o (pin_fall)
   );

   mmt_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) i_prescale (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_sel),
      .osc_i  (osc_tick),
      .tick_o (src_tick)
   );

   mmt_regs #(.CNT_W(CNT_W)) i_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_i         (bus_wr),
      .sel_i        (bus_sel),
      .wdata_i      (bus_wdata),
      .uflow_set_i  (uflow_pulse),
      .edge_set_i   (pinirq_pulse),
      .ctrl_o       (ctrl),
      .src_o        (src_sel),
      .reload_o     (reload_q),
      .flag_uflow_o (irq_uflow),
      .flag_edge_o  (irq_edge),
      .load_o       (load_cnt)
   );

   mmt_core #(.CNT_W(CNT_W)) i_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_i     (ctrl),
      .src_tick_i (src_tick),
      .rise_i     (pin_rise),
      .fall_i     (pin_fall),
      .load_i     (load_cnt),
      .load_val_i (bus_wdata),
      .reload_i   (reload_q),
      .release_i  (rd_release),
      .cnt_o      (cnt_q),
      .cap_o      (cap_q),
      .held_o     (held_q),
      .uflow_o    (uflow_pulse),
      .pinirq_o   (pinirq_pulse)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_sel)
         REG_CTRL:  bus_rdata[3:0] = {ctrl.stop, ctrl.edge_sel, ctrl.mode};
         REG_SRC:   bus_rdata[1:0] = src_sel;
         REG_COUNT: bus_rdata      = measuring ? cap_q : cnt_q;
         default:   bus_rdata[1:0] = {irq_edge, irq_uflow};
      endcase
   end

endmodule

// File: rtl/mmt_checker.sv
module mmt_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic             edge_sel,
   input logic             stop,
   input logic             src_tick,
   input logic             pin_rise,
   input logic             pin_fall,
   input logic             load_cnt,
   input logic             rd_release,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] cap_q,
   input logic             held_q,
   input logic [1:0]       bus_sel,
   input logic [CNT_W-1:0] bus_rdata,
   input logic             irq_uflow,
   input logic             irq_edge
);

   // R5: a stopped counter moves only on a register 2 write
   assert_stop_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !load_cnt) |=> $stable(cnt_q));

   // R4: underflow in timer mode raises the flag
   assert_uflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && !stop && src_tick && cnt_q == '0 && !load_cnt) |=> irq_uflow);

   // R9: a held capture stays put until read
   assert_capture_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && !rd_release) |=> ($stable(cap_q) && held_q));

   // R6: event mode ignores edges it does not count
   assert_event_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && !load_cnt && !(edge_sel ? pin_fall : pin_rise)) |=> $stable(cnt_q));

   // R10: high/low mode flags every edge
   assert_hilo_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && (pin_rise || pin_fall)) |=> irq_edge);

   // R2: unused bits of registers 0 and 1 read 0
   assert_ctrl_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel == 2'd0) |-> (bus_rdata[CNT_W-1:4] == '0));
   assert_src_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel == 2'd1) |-> (bus_rdata[CNT_W-1:2] == '0));

endmodule

bind mmtimer mmt_checker #(.CNT_W(CNT_W)) i_mmt_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (ctrl.mode),
   .edge_sel   (ctrl.edge_sel),
   .stop       (ctrl.stop),
   .src_tick   (src_tick),
   .pin_rise   (pin_rise),
   .pin_fall   (pin_fall),
   .load_cnt   (load_cnt),
   .rd_release (rd_release),
   .cnt_q      (cnt_q),
   .cap_q      (cap_q),
   .held_q     (held_q),
   .bus_sel    (bus_sel),
   .bus_rdata  (bus_rdata),
   .irq_uflow  (irq_uflow),
   .irq_edge   (irq_edge)
);

// File: tb/test_mmtimer.sv
module test_mmtimer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [1:0]  bus_sel = 2'd0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        osc_tick = 1'b0;
   logic        pin_in = 1'b0;
   logic        irq_uflow, irq_edge;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   mmtimer i_mmtimer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .osc_tick(osc_tick), .pin_in(pin_in),
      .irq_uflow(irq_uflow), .irq_edge(irq_edge)
   );

   function automatic logic [15:0] exp_left(input logic [15:0] start, input int steps);
      return start - 16'(steps);
   endfunction

   function automatic logic [15:0] ctrl_word(input int mode, input bit edge_sel, input bit stop);
      return 16'({stop, edge_sel, 2'(mode)});
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      bus_sel = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [1:0] a, input logic [15:0] exp);
      logic [15:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         osc_tick = 1'b1;
         @(negedge clk);
         osc_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic set_pin(input logic v);
      pin_in = v;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, r, first;
      int n, m;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_check("R1 ctrl", 2'd0, 16'h0000);
      rd_check("R1 src", 2'd1, 16'h0000);
      rd_check("R1 count", 2'd2, 16'hFFFF);
      rd_check("R1 flags", 2'd3, 16'h0000);

      // R2 unused bits read zero
      wr(2'd0, 16'hFFFF);
      rd_check("R2 ctrl unused", 2'd0, 16'h000F);
      wr(2'd1, 16'hFFFF);
      rd_check("R2 src unused", 2'd1, 16'h0003);
      wr(2'd0, ctrl_word(0, 0, 0));
      wr(2'd1, 16'd2);

      // R4 underflow and reload
      wr(2'd2, 16'd3);
      ticks(3);
      rd_check("R4 at zero", 2'd2, 16'd0);
      rd_check("R4 no flag yet", 2'd3, 16'h0000);
      ticks(1);
      rd_check("R4 reloaded", 2'd2, 16'd3);
      rd_check("R4 flag set", 2'd3, 16'h0001);
      ticks(1);
      check("R4 flag sticky", {15'd0, irq_uflow}, 16'd1);
      wr(2'd3, 16'h0002);
      rd_check("R2 flag cleared by 0", 2'd3, 16'h0000);

      // R5 stop halts counting
      wr(2'd0, ctrl_word(0, 0, 1));
      ticks(5);
      rd_check("R5 stopped", 2'd2, 16'd2);
      wr(2'd0, ctrl_word(0, 0, 0));

      // R3 source selection
      wr(2'd1, 16'd3);
      ticks(5);
      rd_check("R3 source off", 2'd2, 16'd2);
      wr(2'd1, 16'd1);
      wr(2'd2, 16'd1000);
      repeat (64) @(negedge clk);
      rd_check("R3 clock/2", 2'd2, exp_left(16'd1000, 32));
      wr(2'd1, 16'd0);
      wr(2'd2, 16'd1000);
      repeat (256) @(negedge clk);
      rd_check("R3 clock/16", 2'd2, exp_left(16'd1000, 16));

      // R6 event counting, both edge settings, source ignored
      wr(2'd1, 16'd3);
      wr(2'd0, ctrl_word(2, 0, 0));
      wr(2'd2, 16'd500);
      n = $urandom_range(20, 1);
      for (int i = 0; i < n; i++) begin set_pin(1); set_pin(0); end
      rd_check("R6 rising edges", 2'd2, exp_left(16'd500, n));
      wr(2'd0, ctrl_word(2, 1, 0));
      m = $urandom_range(20, 1);
      for (int i = 0; i < m; i++) begin set_pin(1); set_pin(0); end
      rd_check("R6 falling edges", 2'd2, exp_left(16'd500, n + m));
      set_pin(1);
      rd_check("R6 rising ignored when edge bit 1", 2'd2, exp_left(16'd500, n + m));
      wr(2'd0, ctrl_word(2, 1, 1));
      set_pin(0);
      rd_check("R5 event edge while stopped", 2'd2, exp_left(16'd500, n + m));

      // R11 synchroniser latency
      wr(2'd0, ctrl_word(2, 0, 0));
      wr(2'd2, 16'd100);
      pin_in = 1'b1;
      repeat (2) @(negedge clk);
      check("R11 not after two edges", bus_rdata_cnt(), 16'd100);
      @(negedge clk);
      check("R11 after three edges", bus_rdata_cnt(), 16'd99);
      set_pin(0);

      // R10 pin flag edge selection
      wr(2'd0, ctrl_word(0, 0, 0));
      wr(2'd3, 16'h0000);
      set_pin(1);
      rd_check("R10 rising ignored, bit0", 2'd3, 16'h0000);
      set_pin(0);
      rd_check("R10 falling flags, bit0", 2'd3, 16'h0002);
      wr(2'd0, ctrl_word(0, 1, 0));
      wr(2'd3, 16'h0000);
      set_pin(1);
      rd_check("R10 rising flags, bit1", 2'd3, 16'h0002);
      check("R10 irq_edge port", {15'd0, irq_edge}, 16'd1);
      wr(2'd3, 16'h0000);
      set_pin(0);
      rd_check("R10 falling ignored, bit1", 2'd3, 16'h0000);

      // R7 period measurement, rising trigger
      wr(2'd1, 16'd2);
      wr(2'd0, ctrl_word(1, 1, 0));
      r = 16'd1000;
      wr(2'd2, r);
      set_pin(1);
      rd(2'd2, v);
      set_pin(0);
      for (int i = 0; i < 6; i++) begin
         n = $urandom_range(40, 1);
         ticks(n);
         set_pin(1);
         rd_check("R7 rising period", 2'd2, exp_left(r, n));
         set_pin(0);
      end
      // R7 falling trigger
      wr(2'd0, ctrl_word(1, 0, 0));
      set_pin(1);
      set_pin(0);
      rd(2'd2, v);
      n = $urandom_range(20, 1);
      m = $urandom_range(20, 1);
      ticks(n);
      set_pin(1);
      ticks(m);
      set_pin(0);
      rd_check("R7 falling period", 2'd2, exp_left(r, n + m));

      // R9 hold until read
      wr(2'd0, ctrl_word(1, 1, 0));
      n = $urandom_range(30, 1);
      ticks(n);
      set_pin(1);
      first = exp_left(r, n);
      set_pin(0);
      ticks($urandom_range(30, 1));
      set_pin(1);
      rd_check("R9 first capture kept", 2'd2, first);
      m = $urandom_range(30, 1);
      ticks(m);
      set_pin(0);
      set_pin(1);
      rd_check("R9 held trigger reloaded", 2'd2, exp_left(r, m));

      // R8 high/low measurement, both edge settings
      for (int s = 0; s < 2; s++) begin
         wr(2'd0, ctrl_word(3, s[0], 0));
         r = 16'($urandom_range(60000, 100));
         wr(2'd2, r);
         for (int i = 0; i < 4; i++) begin
            n = $urandom_range(40, 1);
            ticks(n);
            wr(2'd3, 16'h0000);
            set_pin(~pin_in);
            rd_check("R8 high/low width", 2'd2, exp_left(r, n));
            check("R10 high/low flag", {15'd0, irq_edge}, 16'd1);
         end
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   function automatic logic [15:0] bus_rdata_cnt();
      return bus_rdata;
   endfunction

endmodule